// File: doc/BRIEF.md
# Condition Flag Generator and Processor Status Register

This block holds a 16-bit processor status word and derives the four condition flags (carry, zero, negative, overflow) after each ALU operation. The datapath presents the two operands, the ALU result and the carry out of the active width. It also presents an operation class and a byte/word select. The block then decides which flags change and how. Moves and bit-set/bit-clear operations pass through without touching the flags. Logic operations report carry as the inverse of zero. Subtract and compare report carry as "no borrow".

A separate direct-write path lets a bit-set or bit-clear instruction aimed at the status word itself raise or drop any writable bit under a mask. This path covers the flags and the stored control bits: interrupt enable, CPU sleep, oscillator stop and two clock-generator disables. The control bits are only stored here; what they do to the system is handled elsewhere. The upper seven bits are reserved.

Top module: `cond_status_reg`

## Requirements
- R1: On reset the status word is 0x0000, and bits 15 to 9 always read as zero, even when a direct write sets them.
- R2: Bit positions are fixed: carry at bit 0, zero at bit 1, negative at bit 2, interrupt enable at bit 3, CPU sleep at bit 4, oscillator stop at bit 5, clock-generator-0 off at bit 6, clock-generator-1 off at bit 7, overflow at bit 8. The flag outputs equal those bits of the status word.
- R3: On a flag update, negative takes the result's top bit at the active width: bit 7 when `is_byte`=1, bit 15 otherwise.
- R4: On a flag update, zero is set exactly when the result is zero at the active width. In byte mode, result bits 15 to 8 have no effect on any flag.
- R5: For class 0 (add, result = dst + src), carry takes `alu_cout`, which is the carry out of the active width. Overflow is set only when both operands have the same sign and the result's sign differs.
- R6: For class 1 (subtract or compare, result = dst - src, formed as dst + ~src + 1), carry takes `alu_cout`, so 1 means no borrow. Overflow is set only when the operand signs differ and the result's sign differs from dst.
- R7: For class 2 (logic), negative and zero follow the result, carry is the inverse of zero, and overflow is cleared.
- R8: Class 3 (move or bit-set/clear on another register) leaves the whole status word unchanged. So does any cycle with `upd_en`=0 and `wr_en`=0.
- R9: A direct write with `wr_set`=1 sets every writable bit selected by `wr_mask`, and with `wr_set`=0 clears them. Bits that are not selected keep their value.
- R10: When `wr_en` and `upd_en` are both high in one cycle, only the direct write takes effect and the flag update is dropped.
- R11: A flag update never changes bits 7 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | An ALU operation completes this cycle |
| op_cls | input | 2 | Operation class: 0 add, 1 subtract/compare, 2 logic, 3 flag-neutral |
| is_byte | input | 1 | 1 selects byte width, 0 word width |
| src_opnd | input | 16 | Source operand |
| dst_opnd | input | 16 | Destination operand |
| alu_res | input | 16 | ALU result |
| alu_cout | input | 1 | Carry out of the active width |
| wr_en | input | 1 | Direct bit-set/clear to the status word |
| wr_set | input | 1 | 1 sets masked bits, 0 clears them |
| wr_mask | input | 16 | Bit mask for the direct write |
| sr_q | output | 16 | Status word |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every status bit is a register that feeds `sr_q` directly. A wrong next-state value, such as a dropped carry, an overflow computed at the wrong width, or a control bit disturbed by a flag update, therefore appears on the ports one clock after the operation that caused it. A wrong flag persists until a later update or write overwrites it, so the bench compares the full word after every cycle. A reserved bit that sticks, or a write that loses to a same-cycle update, shows at once in that comparison. Sign-boundary operand pairs and junk in the upper result byte during byte operations expose width errors within one update.

// File: rtl/flagstat_pkg.sv
package flagstat_pkg;

  localparam int SR_W = 16;

  localparam int IDX_C     = 0;
  localparam int IDX_Z     = 1;
  localparam int IDX_N     = 2;
  localparam int IDX_IEN   = 3;
  localparam int IDX_SLEEP = 4;
  localparam int IDX_OSCST = 5;
  localparam int IDX_CG0   = 6;
  localparam int IDX_CG1   = 7;
  localparam int IDX_V     = 8;

  localparam logic [SR_W-1:0] WRITABLE_MASK = 16'h01FF;
  localparam logic [SR_W-1:0] FLAG_MASK =
    (SR_W'(1) << IDX_C) | (SR_W'(1) << IDX_Z) |
    (SR_W'(1) << IDX_N) | (SR_W'(1) << IDX_V);

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_HOLD  = 2'd3
  } opc_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flagstat_pkg::*;
#(
  parameter int DW = 16
) (
  input  opc_e          opc,
  input  logic          is_byte,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] res,
  input  logic          cout,
  output flags_t        fl
);

  localparam int HW = DW / 2;

  function automatic logic msb_at(input logic [DW-1:0] v, input logic b);
    return b ? v[HW-1] : v[DW-1];
  endfunction

  function automatic logic zero_at(input logic [DW-1:0] v, input logic b);
    return b ? (v[HW-1:0] == '0) : (v == '0);
  endfunction

  // same-sign operands, result sign flipped
  function automatic logic ovf_add(input logic [DW-1:0] s, input logic [DW-1:0] d,
                                   input logic [DW-1:0] r, input logic b);
    return (msb_at(s, b) == msb_at(d, b)) && (msb_at(r, b) != msb_at(d, b));
  endfunction

  // dst - src: operand signs differ, result sign departs from dst
  function automatic logic ovf_sub(input logic [DW-1:0] s, input logic [DW-1:0] d,
                                   input logic [DW-1:0] r, input logic b);
    return (msb_at(s, b) != msb_at(d, b)) && (msb_at(r, b) != msb_at(d, b));
  endfunction

  logic res_zero;
  logic res_neg;

  assign res_zero = zero_at(res, is_byte);
  assign res_neg  = msb_at(res, is_byte);

  always_comb begin
    fl.z = res_zero;
    fl.n = res_neg;
    unique case (opc)
      OPC_ADD: begin
        fl.c = cout;
        fl.v = ovf_add(src, dst, res, is_byte);
      end
      OPC_SUB: begin
        fl.c = cout;
        fl.v = ovf_sub(src, dst, res, is_byte);
      end
      OPC_LOGIC: begin
        fl.c = ~res_zero;
        fl.v = 1'b0;
      end
      default: begin
        fl.c = 1'b0;
        fl.v = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sr_store.sv
module sr_store
  import flagstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_arith,
  input  flags_t          fl_new,
  input  logic            dir_wr,
  input  logic            wr_set,
  input  logic [SR_W-1:0] wr_mask,
  output logic [SR_W-1:0] sr_q
);

  logic [SR_W-1:0] flag_vec;

  always_comb begin
    flag_vec        = '0;
    flag_vec[IDX_C] = fl_new.c;
    flag_vec[IDX_Z] = fl_new.z;
    flag_vec[IDX_N] = fl_new.n;
    flag_vec[IDX_V] = fl_new.v;
  end

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    if (WRITABLE_MASK[i]) begin : g_store
      logic nxt;
      always_comb begin
        if (dir_wr && wr_mask[i])
          nxt = wr_set;
        else if (!dir_wr && upd_arith && FLAG_MASK[i])
          nxt = flag_vec[i];
        else
          nxt = sr_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else        sr_q[i] <= nxt;
      end
    end else begin : g_rsvd
      assign sr_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/cond_status_reg.sv
module cond_status_reg
  import flagstat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [1:0]    op_cls,
  input  logic          is_byte,
  input  logic [DW-1:0] src_opnd,
  input  logic [DW-1:0] dst_opnd,
  input  logic [DW-1:0] alu_res,
  input  logic          alu_cout,
  input  logic          wr_en,
  input  logic          wr_set,
  input  logic [15:0]   wr_mask,
  output logic [15:0]   sr_q,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v
);

  opc_e   opc;
  flags_t fl_new;
  logic   upd_arith;
  logic   dir_wr;

  assign opc       = opc_e'(op_cls);
  assign upd_arith = upd_en && (opc != OPC_HOLD);
  assign dir_wr    = wr_en;

  flag_calc #(.DW(DW)) u_calc (
    .opc     (opc),
    .is_byte (is_byte),
    .src     (src_opnd),
    .dst     (dst_opnd),
    .res     (alu_res),
    .cout    (alu_cout),
    .fl      (fl_new)
  );

  sr_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_arith (upd_arith),
    .fl_new    (fl_new),
    .dir_wr    (dir_wr),
    .wr_set    (wr_set),
    .wr_mask   (wr_mask),
    .sr_q      (sr_q)
  );

  assign flag_c = sr_q[IDX_C];
  assign flag_z = sr_q[IDX_Z];
  assign flag_n = sr_q[IDX_N];
  assign flag_v = sr_q[IDX_V];

endmodule

// File: rtl/sr_flag_checker.sv
module sr_flag_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_en,
  input logic          upd_arith,
  input logic [1:0]    op_cls,
  input logic          is_byte,
  input logic [DW-1:0] src_opnd,
  input logic [DW-1:0] dst_opnd,
  input logic          dir_wr,
  input logic          wr_set,
  input logic [15:0]   wr_mask,
  input logic [15:0]   sr_q,
  input logic          flag_c,
  input logic          flag_z
);

  localparam int HW = DW / 2;

  logic            src_sign;
  logic            dst_sign;
  logic [15:0]     wmask;

  assign src_sign = is_byte ? src_opnd[HW-1] : src_opnd[DW-1];
  assign dst_sign = is_byte ? dst_opnd[HW-1] : dst_opnd[DW-1];
  assign wmask    = wr_mask & 16'h01FF;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> sr_q == 16'h0000);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[15:9] == 7'h00);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !dir_wr && op_cls == 2'd0 && src_sign != dst_sign) |=> sr_q[8] == 1'b0);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !dir_wr && op_cls == 2'd1 && src_sign == dst_sign) |=> sr_q[8] == 1'b0);

  a_r7_carry_not_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !dir_wr && op_cls == 2'd2) |=> (flag_c == !flag_z) && !sr_q[8]);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && (!upd_en || op_cls == 2'd3)) |=> $stable(sr_q));

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && wr_set) |=> (sr_q & $past(wmask)) == $past(wmask));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && !wr_set) |=> (sr_q & $past(wmask)) == 16'h0000);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (sr_q & ~$past(wmask)) == ($past(sr_q) & ~$past(wmask)));

  a_r11_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_arith && !dir_wr) |=> $stable(sr_q[7:3]));

endmodule

bind cond_status_reg sr_flag_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_en    (upd_en),
  .upd_arith (upd_arith),
  .op_cls    (op_cls),
  .is_byte   (is_byte),
  .src_opnd  (src_opnd),
  .dst_opnd  (dst_opnd),
  .dir_wr    (dir_wr),
  .wr_set    (wr_set),
  .wr_mask   (wr_mask),
  .sr_q      (sr_q),
  .flag_c    (flag_c),
  .flag_z    (flag_z)
);

// File: tb/tb_cond_status_reg.sv
`timescale 1ns/1ps
module tb_cond_status_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [1:0]  op_cls = 2'd3;
  logic        is_byte = 1'b0;
  logic [15:0] src_opnd = '0;
  logic [15:0] dst_opnd = '0;
  logic [15:0] alu_res = '0;
  logic        alu_cout = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_set = 1'b0;
  logic [15:0] wr_mask = '0;
  logic [15:0] sr_q;
  logic        flag_c, flag_z, flag_n, flag_v;

  int n_run = 0;
  int n_fail = 0;
  int model_sr = 0;

  always #5 clk = ~clk;

  cond_status_reg dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
    .is_byte(is_byte), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
    .alu_res(alu_res), .alu_cout(alu_cout), .wr_en(wr_en), .wr_set(wr_set),
    .wr_mask(wr_mask), .sr_q(sr_q), .flag_c(flag_c), .flag_z(flag_z),
    .flag_n(flag_n), .flag_v(flag_v)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, int'(sr_q), model_sr);
    check({tag, " R2 outputs"}, {flag_v, flag_n, flag_z, flag_c},
          {model_sr[8], model_sr[2], model_sr[1], model_sr[0]});
  endtask

  // One cycle: drive op and/or write, update model, compare after the edge
  task automatic step(input bit upd, input int op, input bit byt, input int a, input int b,
                      input bit wr, input bit set, input int mask, input int junk,
                      input string tag);
    int w, m, half, full, res, cy, sa, sb, sv, vv;
    @(negedge clk);
    w = byt ? 8 : 16;
    m = (1 << w) - 1;
    half = 1 << (w - 1);
    a = a & 'hFFFF;
    b = b & 'hFFFF;
    sa = ((a & m) >= half) ? (a & m) - (1 << w) : (a & m);
    sb = ((b & m) >= half) ? (b & m) - (1 << w) : (b & m);
    cy = 0; vv = 0;
    case (op)
      0: begin full = (b & m) + (a & m); sv = sb + sa; end
      1: begin full = (b & m) + ((~a) & m) + 1; sv = sb - sa; end
      2: begin full = (a ^ b) & m; sv = 0; end
      default: begin full = b & m; sv = 0; end
    endcase
    res = full & m;
    if (op < 2) begin
      cy = (full >> w) & 1;
      vv = (sv >= half || sv < -half) ? 1 : 0;
    end
    upd_en = upd; op_cls = 2'(op); is_byte = byt;
    src_opnd = 16'(a); dst_opnd = 16'(b);
    alu_res = 16'(res | (byt ? (junk & 'hFF00) : 0));
    alu_cout = 1'(cy);
    wr_en = wr; wr_set = set; wr_mask = 16'(mask);
    if (wr) begin
      if (set) model_sr = model_sr | (mask & 'h1FF);
      else     model_sr = model_sr & ~(mask & 'h1FF);
    end else if (upd && op != 3) begin
      model_sr = model_sr & ~'h107;
      if (op == 2) cy = (res != 0) ? 1 : 0;
      model_sr = model_sr | cy | ((res == 0) ? 2 : 0) | ((res >= half) ? 4 : 0) | (vv << 8);
    end
    @(posedge clk);
    #1;
    check_all(tag);
    upd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", int'(sr_q), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 word 1 + FFFF -> C,Z
    step(1, 0, 0, 'h0001, 'hFFFF, 0, 0, 0, 0, "R5 add carry");
    check("R5 C,Z", {flag_v, flag_n, flag_z, flag_c}, 4'b0011);
    // R3/R5 7FFF + 1 -> N,V
    step(1, 0, 0, 'h0001, 'h7FFF, 0, 0, 0, 0, "R3 add ovf");
    check("R3 N,V", {flag_v, flag_n, flag_z, flag_c}, 4'b1100);
    // R4/R5 byte 80 + 80 with junk upper result -> C,Z,V
    step(1, 0, 1, 'hAB80, 'h1280, 0, 0, 0, 'h5500, "R4 byte add");
    check("R4 C,Z,V", {flag_v, flag_n, flag_z, flag_c}, 4'b1011);
    // R6 compare 10 vs 5 -> C
    step(1, 1, 0, 5, 10, 0, 0, 0, 0, "R6 cmp gt");
    check("R6 C only", {flag_v, flag_n, flag_z, flag_c}, 4'b0001);
    step(1, 1, 0, 10, 10, 0, 0, 0, 0, "R6 cmp eq");
    check("R6 C,Z", {flag_v, flag_n, flag_z, flag_c}, 4'b0011);
    // R6 byte 7F - 80 -> N,V, no C
    step(1, 1, 1, 'h80, 'h7F, 0, 0, 0, 'hFF00, "R6 byte sub");
    check("R6 N,V", {flag_v, flag_n, flag_z, flag_c}, 4'b1100);
    // R7 logic
    step(1, 2, 0, 'h00AA, 'h00AA, 0, 0, 0, 0, "R7 xor zero");
    check("R7 Z no C", {flag_v, flag_n, flag_z, flag_c}, 4'b0010);
    step(1, 2, 0, 'h00AA, 'hFFFF, 0, 0, 0, 0, "R7 xor nonzero");
    check("R7 C,N", {flag_v, flag_n, flag_z, flag_c}, 4'b0101);
    // R1/R9 set everything
    step(0, 3, 0, 0, 0, 1, 1, 'hFFFF, 0, "R9 set all");
    check("R1 reserved", int'(sr_q), 'h01FF);
    // R8 hold class
    step(1, 3, 0, 'h1234, 'h0000, 0, 0, 0, 0, "R8 hold");
    check("R8 unchanged", int'(sr_q), 'h01FF);
    // R11 flag update keeps control bits
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, "R11 ctrl kept");
    check("R11 bits 7..3", int'(sr_q[7:3]), 'h1F);
    // R10 write beats same-cycle update
    step(1, 0, 0, 'hFFFF, 1, 1, 0, 'h0002, 0, "R10 priority");
    check("R10 only Z cleared", int'(sr_q), 'h00F8);
    // R9 clear a subset
    step(0, 3, 0, 0, 0, 1, 0, 'h0018, 0, "R9 clear");
    check("R9 mask clear", int'(sr_q), 'h00E0);

    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom_range(0, 3));
      bit byt = 1'($urandom_range(0, 1));
      bit upd = ($urandom_range(0, 7) != 0);
      bit wr = ($urandom_range(0, 5) == 0);
      int a = int'($urandom_range(0, 65535));
      int b = int'($urandom_range(0, 65535));
      string tag;
      if (i % 5 == 0) b = a;
      if (i % 7 == 0) a = byt ? 'h80 : 'h8000;
      if (wr) tag = upd ? "R10 random" : "R9 random";
      else if (!upd || op == 3) tag = "R8 random";
      else if (op == 0) tag = "R5 random";
      else if (op == 1) tag = "R6 random";
      else tag = "R7 random";
      step(upd, op, byt, a, b, wr, 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), tag);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule